// File: doc/BRIEF.md
# Burst Beat Address Walker

This block belongs to a memory-mapped slave on an AXI4 fabric. It takes one address-channel request: a start address, a length field, a size field and a burst kind. It then produces a stream of beats for the data path. Each beat carries the local byte address, its index within the burst, a last-beat marker and an error marker. Incrementing and wrapping bursts are walked in full. Fixed bursts repeat the start address on every beat.

Requests that the slave cannot honour are still walked for the full beat count, so that the data channel stays in step. These are the reserved burst kind, a wrapping length other than 2, 4, 8 or 16 beats, and a beat size wider than the data bus. On such a burst every beat carries the error marker, and a downstream response stage can turn the marker into SLVERR. Only the low `LOCAL_W` address bits are kept, so addresses above the slave's window alias into it. The window must be wide enough to hold one full wrap span: `LOCAL_W` ≥ `MAX_SIZE` + 4.

Both sides use valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from that point until the cycle after the last beat has been taken. The beat stream may be stalled indefinitely by holding `beat_ready` low. While it is stalled, every beat output holds its value. The next address is taken only on a beat handshake.

Top module: `burst_addr_walker`

## Requirements
- R1: `req_ready` is high exactly when no burst is in progress. A request is taken on `req_valid && req_ready`, and no further request is taken before the cycle after the last beat handshake.
- R2: `beat_valid` rises the cycle after a request is taken and stays high until the last beat handshake. While `beat_valid && !beat_ready`, `beat_addr`, `beat_idx`, `beat_last` and `beat_err` hold their values.
- R3: A burst delivers exactly `req_len`+1 beats. `beat_idx` starts at 0 and rises by one per handshake, and `beat_last` is high only on the beat where `beat_idx` equals `req_len`. Lengths of up to 256 beats are supported.
- R4: Burst kind 2'b01 (incrementing): beat 0 carries the start address. Beat i>0 carries the start address aligned down to 2^size bytes, plus i·2^size, modulo 2^`LOCAL_W`.
- R5: Burst kind 2'b10 (wrapping) with a length field of 1, 3, 7 or 15: let span be (len+1)·2^size. The boundary is the size-aligned start rounded down to a multiple of span. Each following beat adds 2^size and returns to the boundary on reaching boundary+span. Beat 0 carries the start address.
- R6: Burst kind 2'b00 (fixed): every beat carries the start address.
- R7: `beat_err` is high on every beat of a burst whose kind is 2'b11, or whose size exceeds `MAX_SIZE`, or whose kind is 2'b10 with a length field outside {1,3,7,15}. Such a burst still has len+1 beats, and all of them carry the start address.
- R8: Only `req_addr[LOCAL_W-1:0]` is used. Two requests that differ only above that range produce identical beats.
- R9: After reset `req_ready` is 1 and `beat_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | 8 | Beats minus one |
| req_size | input | 3 | log2 of bytes per beat |
| req_kind | input | 2 | 00 fixed, 01 incrementing, 10 wrapping, 11 reserved |
| beat_valid | output | 1 | Beat offered |
| beat_ready | input | 1 | Beat taken by data path |
| beat_addr | output | LOCAL_W | Local byte address of beat |
| beat_idx | output | 8 | Beat index within burst |
| beat_last | output | 1 | Final beat of burst |
| beat_err | output | 1 | Request illegal, answer with error |

## Verification
A corrupted address register or a wrong next-address term appears at `beat_addr` on the very next handshake. The bench compares every beat of every burst against an arithmetic model, so such a fault is caught on its first beat. A corrupted beat counter or busy flag shows up as a misplaced `beat_last`, a burst that is too short or too long, or `req_ready` at the wrong level; each of these is seen at the beat or cycle where it happens. The sweep covers every kind, five sizes (one of them illegal), lengths that straddle the wrap limits and the 256-beat maximum, and start addresses that are unaligned, that carry high bits, or that sit near the top of the window. Back-pressure is applied on every third cycle.

// File: rtl/burst_walk_pkg.sv
package burst_walk_pkg;

  localparam int unsigned LEN_W  = 8;
  localparam int unsigned SIZE_W = 3;

  typedef enum logic [1:0] {
    KIND_FIXED = 2'b00,
    KIND_INCR  = 2'b01,
    KIND_WRAP  = 2'b10,
    KIND_RSVD  = 2'b11
  } burst_kind_e;

  // Per-burst settings held for the whole walk.
  typedef struct packed {
    burst_kind_e             kind;
    logic [SIZE_W-1:0]       size;
    logic [LEN_W-1:0]        len;
    logic                    err;
  } burst_ctx_t;

endpackage

// File: rtl/bw_req_check.sv
// Legality screen for an incoming request.
module bw_req_check
  import burst_walk_pkg::*;
#(
  parameter int unsigned MAX_SIZE      = 3,
  parameter int unsigned WRAP_MAX_LOG2 = 4
) (
  input  burst_kind_e        kind,
  input  logic [LEN_W-1:0]   len,
  input  logic [SIZE_W-1:0]  size,
  output logic               err
);

  logic [WRAP_MAX_LOG2-1:0] wrap_hit;

  // One comparator per legal wrap length: 2, 4, ... 2^WRAP_MAX_LOG2 beats.
  for (genvar k = 1; k <= WRAP_MAX_LOG2; k++) begin : g_wrap_len
    localparam logic [LEN_W-1:0] LegalLen = LEN_W'((1 << k) - 1);
    assign wrap_hit[k-1] = (len == LegalLen);
  end

  logic size_bad;
  logic wrap_bad;

  always_comb begin
    size_bad = (size > SIZE_W'(MAX_SIZE));
    wrap_bad = (kind == KIND_WRAP) && !(|wrap_hit);
    err      = (kind == KIND_RSVD) || size_bad || wrap_bad;
  end

endmodule

// File: rtl/bw_next_addr.sv
// Combinational successor of the current beat address.
module bw_next_addr
  import burst_walk_pkg::*;
#(
  parameter int unsigned LOCAL_W = 12
) (
  input  logic [LOCAL_W-1:0] cur,
  input  burst_ctx_t         ctx,
  output logic [LOCAL_W-1:0] nxt
);

  localparam int unsigned SpanW = LOCAL_W + 1;

  logic [LOCAL_W-1:0] step;
  logic [LOCAL_W-1:0] size_mask;
  logic [LOCAL_W-1:0] aligned;
  logic [LOCAL_W-1:0] bumped;
  logic [LEN_W:0]     beats;
  logic [SpanW-1:0]   span;
  logic [LOCAL_W-1:0] wrap_mask;
  logic [LOCAL_W-1:0] wrap_next;

  always_comb begin
    step      = LOCAL_W'(1) << ctx.size;
    size_mask = step - LOCAL_W'(1);
    aligned   = cur & ~size_mask;
    bumped    = aligned + step;
    beats     = {1'b0, ctx.len} + (LEN_W+1)'(1);
    span      = SpanW'(beats) << ctx.size;
    wrap_mask = span[LOCAL_W-1:0] - LOCAL_W'(1);
    wrap_next = (aligned & ~wrap_mask) | (bumped & wrap_mask);

    if (ctx.err) begin
      nxt = cur;
    end else begin
      unique case (ctx.kind)
        KIND_INCR: nxt = bumped;
        KIND_WRAP: nxt = wrap_next;
        default:   nxt = cur;
      endcase
    end
  end

endmodule

// File: rtl/bw_beat_ctrl.sv
// Busy flag and beat counter for one burst.
module bw_beat_ctrl
  import burst_walk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic             take,
  output logic             busy,
  output logic [LEN_W-1:0] idx,
  output logic             last
);

  assign last = busy && (idx == len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy && take) begin
      if (last) begin
        busy <= 1'b0;
      end else begin
        idx <= idx + LEN_W'(1);
      end
    end
  end

endmodule

// File: rtl/burst_addr_walker.sv
// Walks the beat addresses of one AXI4 burst request at a time.
module burst_addr_walker
  import burst_walk_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned LOCAL_W  = 12,
  parameter int unsigned MAX_SIZE = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [LEN_W-1:0]    req_len,
  input  logic [SIZE_W-1:0]   req_size,
  input  logic [1:0]          req_kind,
  output logic                beat_valid,
  input  logic                beat_ready,
  output logic [LOCAL_W-1:0]  beat_addr,
  output logic [LEN_W-1:0]    beat_idx,
  output logic                beat_last,
  output logic                beat_err
);

  burst_kind_e        kind_in;
  logic               err_in;
  logic               busy;
  logic               accept;
  logic               fire;
  burst_ctx_t         ctx_q;
  logic [LOCAL_W-1:0] addr_q;
  logic [LOCAL_W-1:0] addr_nxt;

  assign kind_in    = burst_kind_e'(req_kind);
  assign req_ready  = !busy;
  assign accept     = req_valid && req_ready;
  assign beat_valid = busy;
  assign fire       = beat_valid && beat_ready;

  bw_req_check #(
    .MAX_SIZE      (MAX_SIZE),
    .WRAP_MAX_LOG2 (4)
  ) u_check (
    .kind (kind_in),
    .len  (req_len),
    .size (req_size),
    .err  (err_in)
  );

  bw_beat_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .len   (ctx_q.len),
    .take  (beat_ready),
    .busy  (busy),
    .idx   (beat_idx),
    .last  (beat_last)
  );

  bw_next_addr #(
    .LOCAL_W (LOCAL_W)
  ) u_next (
    .cur (addr_q),
    .ctx (ctx_q),
    .nxt (addr_nxt)
  );

  // Context and address registers; high address bits are dropped here.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q  <= '{kind: KIND_FIXED, size: '0, len: '0, err: 1'b0};
      addr_q <= '0;
    end else if (accept) begin
      ctx_q  <= '{kind: kind_in, size: req_size, len: req_len, err: err_in};
      addr_q <= req_addr[LOCAL_W-1:0];
    end else if (fire && !beat_last) begin
      addr_q <= addr_nxt;
    end
  end

  assign beat_addr = addr_q;
  assign beat_err  = ctx_q.err;

endmodule

// File: rtl/bw_checker.sv
// Protocol and walk properties, bound onto the top module.
module bw_checker #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned LOCAL_W  = 12,
  parameter int unsigned MAX_SIZE = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [7:0]         req_len,
  input logic [2:0]         req_size,
  input logic [1:0]         req_kind,
  input logic               beat_valid,
  input logic               beat_ready,
  input logic [LOCAL_W-1:0] beat_addr,
  input logic [7:0]         beat_idx,
  input logic               beat_last,
  input logic               beat_err
);

  logic               acc;
  logic               fire;
  logic [1:0]         k_kind;
  logic [2:0]         k_size;
  logic [7:0]         k_len;
  logic [LOCAL_W-1:0] k_start;
  logic [LOCAL_W-1:0] k_step;
  logic [LOCAL_W:0]   k_span;
  logic [LOCAL_W-1:0] k_wmask;

  assign acc  = req_valid && req_ready;
  assign fire = beat_valid && beat_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_kind  <= '0;
      k_size  <= '0;
      k_len   <= '0;
      k_start <= '0;
    end else if (acc) begin
      k_kind  <= req_kind;
      k_size  <= req_size;
      k_len   <= req_len;
      k_start <= req_addr[LOCAL_W-1:0];
    end
  end

  always_comb begin
    k_step  = LOCAL_W'(1) << k_size;
    k_span  = (LOCAL_W+1)'({1'b0, k_len} + 9'd1) << k_size;
    k_wmask = k_span[LOCAL_W-1:0] - LOCAL_W'(1);
  end

  assert_no_req_while_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !req_ready);

  assert_idle_after_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && beat_last) |=> (!beat_valid && req_ready));

  assert_hold_on_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr) && $stable(beat_idx)
                                     && $stable(beat_last)));

  assert_first_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (beat_valid && beat_idx == 8'd0));

  assert_idx_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !beat_last) |=> (beat_valid && beat_idx == $past(beat_idx) + 8'd1));

  assert_last_at_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (beat_last == (beat_idx == k_len)));

  assert_incr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !beat_last && !beat_err && k_kind == 2'b01)
      |=> (beat_addr == (($past(beat_addr) & ~(k_step - LOCAL_W'(1))) + k_step)));

  assert_wrap_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_err && k_kind == 2'b10)
      |-> (((beat_addr ^ k_start) & ~k_wmask) == '0));

  assert_fixed_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && k_kind == 2'b00) |-> (beat_addr == k_start));

  assert_rsvd_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && k_kind == 2'b11) |-> (beat_err && beat_addr == k_start));

  assert_err_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !(fire && beat_last)) |=> (beat_valid && $stable(beat_err)));

  assert_trim_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (beat_addr == $past(req_addr[LOCAL_W-1:0])));

endmodule

bind burst_addr_walker bw_checker #(
  .ADDR_W   (ADDR_W),
  .LOCAL_W  (LOCAL_W),
  .MAX_SIZE (MAX_SIZE)
) u_bw_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .req_len    (req_len),
  .req_size   (req_size),
  .req_kind   (req_kind),
  .beat_valid (beat_valid),
  .beat_ready (beat_ready),
  .beat_addr  (beat_addr),
  .beat_idx   (beat_idx),
  .beat_last  (beat_last),
  .beat_err   (beat_err)
);

// File: tb/tb_burst_addr_walker.sv
`timescale 1ns/1ps
module tb_burst_addr_walker;

  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned LOCAL_W  = 12;
  localparam int unsigned MAX_SIZE = 3;
  localparam longint      LMASK    = (64'd1 << LOCAL_W) - 1;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               req_valid = 1'b0;
  logic               req_ready;
  logic [ADDR_W-1:0]  req_addr = '0;
  logic [7:0]         req_len = '0;
  logic [2:0]         req_size = '0;
  logic [1:0]         req_kind = '0;
  logic               beat_valid;
  logic               beat_ready = 1'b0;
  logic [LOCAL_W-1:0] beat_addr;
  logic [7:0]         beat_idx;
  logic               beat_last;
  logic               beat_err;

  int checks   = 0;
  int failures = 0;
  int cyc      = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  burst_addr_walker #(
    .ADDR_W   (ADDR_W),
    .LOCAL_W  (LOCAL_W),
    .MAX_SIZE (MAX_SIZE)
  ) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_len    (req_len),
    .req_size   (req_size),
    .req_kind   (req_kind),
    .beat_valid (beat_valid),
    .beat_ready (beat_ready),
    .beat_addr  (beat_addr),
    .beat_idx   (beat_idx),
    .beat_last  (beat_last),
    .beat_err   (beat_err)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_err(input int len, input int sz, input int kd);
    bit wrap_ok;
    wrap_ok = (len == 1) || (len == 3) || (len == 7) || (len == 15);
    return (kd == 3) || (sz > MAX_SIZE) || (kd == 2 && !wrap_ok);
  endfunction

  function automatic longint exp_addr(input longint st, input int len, input int sz,
                                      input int kd, input int i);
    longint a0, bytes, al, span, base;
    a0    = st & LMASK;
    bytes = 64'd1 << sz;
    if (i == 0 || exp_err(len, sz, kd) || kd == 0) return a0;
    al = a0 & ~(bytes - 1);
    if (kd == 1) return (al + i * bytes) & LMASK;
    span = bytes * (len + 1);
    base = al & ~(span - 1);
    return base + ((al - base + i * bytes) % span);
  endfunction

  function automatic string tag_of(input longint st, input int len, input int sz, input int kd);
    string t;
    if (exp_err(len, sz, kd)) t = "R7";
    else if (kd == 0) t = "R6";
    else if (kd == 1) t = "R4";
    else t = "R5";
    if ((st & ~LMASK) != 0) t = {t, "/R8"};
    return t;
  endfunction

  task automatic run_burst(input logic [31:0] st, input int len, input int sz, input int kd);
    int got;
    bit stalled;
    bit rdy;
    logic [LOCAL_W-1:0] held;
    string t;
    t = tag_of(st, len, sz, kd);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready while idle", req_ready, 1);
    req_valid = 1'b1;
    req_addr  = st;
    req_len   = 8'(len);
    req_size  = 3'(sz);
    req_kind  = 2'(kd);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1", "ready low during burst", req_ready, 0);
    got = 0;
    stalled = 1'b0;
    held = '0;
    while (got <= len) begin
      if (!beat_valid) begin
        chk(1'b0, "R2", "beat_valid dropped early", got, len + 1);
        break;
      end
      if (stalled) chk(beat_addr == held, "R2", "address moved while stalled", beat_addr, held);
      rdy = ((cyc % 3) != 2);
      beat_ready = rdy;
      if (rdy) begin
        chk(longint'(beat_addr) == exp_addr(st, len, sz, kd, got), t, "beat address",
            beat_addr, exp_addr(st, len, sz, kd, got));
        chk(beat_idx == 8'(got) && beat_last == (got == len), "R3", "index/last",
            {beat_idx, 7'd0, beat_last}, {8'(got), 7'd0, (got == len)});
        chk(beat_err == exp_err(len, sz, kd), "R7", "error marker",
            beat_err, exp_err(len, sz, kd));
        got++;
        stalled = 1'b0;
      end else begin
        held = beat_addr;
        stalled = 1'b1;
      end
      @(negedge clk);
    end
    beat_ready = 1'b0;
    chk(!beat_valid && req_ready, "R3", "idle after len+1 beats",
        {beat_valid, req_ready}, 2'b01);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lens[8];
    logic [31:0] starts[4];
    lens   = '{0, 1, 2, 3, 7, 15, 16, 255};
    starts = '{32'h0000_0000, 32'h0000_0A37, 32'hDEAD_BFF8, 32'h7000_0123};
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && beat_valid == 1'b0, "R9", "reset state",
        {req_ready, beat_valid}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && beat_valid == 1'b0, "R9", "state after reset release",
        {req_ready, beat_valid}, 2'b10);
    for (int kd = 0; kd < 4; kd++)
      for (int sz = 0; sz <= MAX_SIZE + 1; sz++)
        for (int li = 0; li < 8; li++)
          for (int si = 0; si < 4; si++)
            run_burst(starts[si], lens[li], sz, kd);
    // Aliasing: same low bits, different high bits (R8).
    run_burst(32'h0000_0470, 7, 2, 2);
    run_burst(32'hFFFF_F470, 7, 2, 2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule